// File: doc/BRIEF.md
# Quad Undervoltage Supervisor Timing Logic

This block is the digital timing core of a four-channel supply supervisor. Each channel receives one bit from an external comparator that is high when the monitored rail is above its trip level. A channel reports good only after its rail has stayed above the trip level without a break for a long qualification window. A good channel is dropped only when the rail stays low for a short filter window, so brief transients are ignored. A combined power-good output is high only when every channel reports good.

The timing logic runs only while the enable input and the bias-valid input are both high. When either goes low, every channel loses its qualification. Power-good drops in the same cycle, and each channel status drops at the next clock edge. When both return high, every channel must qualify again from zero. A channel that is not used is tied permanently high and qualifies like any other channel. Both windows are parameters counted in clock cycles.

Top module: `uvsup_quad`

## Requirements
- R1: A channel's status rises at the clock edge on which its above-threshold input has been sampled high on QUAL_CYC consecutive edges while the block runs.
- R2: A single low sample during qualification clears that channel's count, so a fresh run of QUAL_CYC consecutive high samples is needed.
- R3: A good channel's status falls at the edge on which its input has been sampled low on GLITCH_CYC consecutive edges.
- R4: A dip of fewer than GLITCH_CYC low samples leaves the status high, and the return to high clears the fall count.
- R5: Power-good is high exactly when the block runs and all four statuses are high. A failing channel does not disturb the other statuses.
- R6: With enable low, power-good is low in the same cycle, and every status is low from the next clock edge.
- R7: After enable returns high with all inputs valid, statuses and power-good rise only after the full QUAL_CYC window.
- R8: While bias-valid is low, all statuses and power-good stay low. Qualification restarts from zero when it returns high.
- R9: Synchronous active-high reset drives all outputs low and clears every count.
- R10: A channel tied permanently high qualifies in QUAL_CYC cycles and never blocks power-good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Monitoring enable, high to run |
| pwr_ok_i | input | 1 | Bias supply valid, low means lockout |
| above_i | input | N_CH | Per-channel comparator result, 1 = above trip level |
| status_o | output | N_CH | Per-channel qualified status |
| pgood_o | output | 1 | Combined power-good |

## Verification
The assertions check on every cycle that a status rises only after a high sample and falls only after a low sample or a loss of run. They also check that a low sample during qualification clears the count, that counts stay inside their windows, that power-good never stands high without all statuses, and that enable low or lockout forces the outputs low. The exact lengths of the qualification and filter windows, the recovery after a short dip, and the full restart after enable or bias returns can only be shown by the bench's timed scenarios. In those scenarios the bench compares the outputs cycle by cycle against its own model.

// File: rtl/uvsup_pkg.sv
package uvsup_pkg;

    typedef enum logic {
        CH_WAIT = 1'b0,
        CH_GOOD = 1'b1
    } ch_state_e;

    function automatic int cnt_width(input int qual, input int glitch);
        int big;
        big = (qual > glitch) ? qual : glitch;
        return (big < 2) ? 1 : $clog2(big);
    endfunction

endpackage

// File: rtl/uvsup_chan.sv
module uvsup_chan
    import uvsup_pkg::*;
#(
    parameter int QUAL_CYC   = 16,
    parameter int GLITCH_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic above_i,
    output logic status_o
);
    localparam int CW = cnt_width(QUAL_CYC, GLITCH_CYC);
    localparam logic [CW-1:0] QLAST = CW'(QUAL_CYC - 1);
    localparam logic [CW-1:0] GLAST = CW'(GLITCH_CYC - 1);

    ch_state_e      st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!run_i) begin
            st_d  = CH_WAIT;
            cnt_d = '0;
        end else begin
            case (st_q)
                CH_WAIT: begin
                    if (above_i) begin
                        if (cnt_q == QLAST) begin
                            st_d  = CH_GOOD;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end else begin
                        cnt_d = '0;
                    end
                end
                default: begin
                    if (!above_i) begin
                        if (cnt_q == GLAST) begin
                            st_d  = CH_WAIT;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end else begin
                        cnt_d = '0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= CH_WAIT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign status_o = (st_q == CH_GOOD);

    AST_RISE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o) |-> ($past(above_i) && $past(run_i))); // R1
    AST_QUAL_RESTART: assert property (@(posedge clk) disable iff (rst)
        (!status_o && run_i && !above_i) |=> (cnt_q == '0)); // R2
    AST_FALL_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(status_o) |-> (!$past(above_i) || !$past(run_i))); // R3
    AST_DIP_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (status_o && run_i && above_i) |=> (status_o && cnt_q == '0)); // R4
    AST_GATED_LOW: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !status_o); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        status_o ? (cnt_q <= GLAST) : (cnt_q <= QLAST)); // R1

endmodule

// File: rtl/uvsup_pgood.sv
module uvsup_pgood #(
    parameter int N_CH = 4
) (
    input  logic            run_i,
    input  logic [N_CH-1:0] status_i,
    output logic            pgood_o
);
    assign pgood_o = run_i & (&status_i);
endmodule

// File: rtl/uvsup_quad.sv
module uvsup_quad #(
    parameter int N_CH       = 4,
    parameter int QUAL_CYC   = 16,
    parameter int GLITCH_CYC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en_i,
    input  logic            pwr_ok_i,
    input  logic [N_CH-1:0] above_i,
    output logic [N_CH-1:0] status_o,
    output logic            pgood_o
);
    logic run;
    assign run = en_i & pwr_ok_i;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        uvsup_chan #(
            .QUAL_CYC   (QUAL_CYC),
            .GLITCH_CYC (GLITCH_CYC)
        ) u_chan (
            .clk      (clk),
            .rst      (rst),
            .run_i    (run),
            .above_i  (above_i[g]),
            .status_o (status_o[g])
        );
    end

    uvsup_pgood #(.N_CH(N_CH)) u_pg (
        .run_i    (run),
        .status_i (status_o),
        .pgood_o  (pgood_o)
    );

    AST_PG_ALL_GOOD: assert property (@(posedge clk) disable iff (rst)
        pgood_o |-> (&status_o)); // R5
    AST_EN_DROP: assert property (@(posedge clk) disable iff (rst)
        !en_i |-> !pgood_o); // R6
    AST_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok_i |=> (status_o == '0 && !pgood_o)); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (status_o == '0)); // R9

endmodule

// File: tb/tb_uvsup_quad.sv
`timescale 1ns/1ps
module tb_uvsup_quad;
    localparam int N  = 4;
    localparam int Q  = 12;
    localparam int G  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic pw = 1'b0;
    logic [N-1:0] above = '0;
    logic [N-1:0] status;
    logic pgood;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    uvsup_quad #(.N_CH(N), .QUAL_CYC(Q), .GLITCH_CYC(G)) dut (
        .clk(clk), .rst(rst), .en_i(en), .pwr_ok_i(pw),
        .above_i(above), .status_o(status), .pgood_o(pgood)
    );

    // Behavioural model written from the requirements
    logic [N-1:0] m_st = '0;
    int m_cnt [N];

    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst || !(en && pw)) begin
                m_st[i]  <= 1'b0;
                m_cnt[i] <= 0;
            end else if (!m_st[i]) begin
                if (!above[i]) m_cnt[i] <= 0;
                else if (m_cnt[i] + 1 >= Q) begin m_st[i] <= 1'b1; m_cnt[i] <= 0; end
                else m_cnt[i] <= m_cnt[i] + 1;
            end else begin
                if (above[i]) m_cnt[i] <= 0;
                else if (m_cnt[i] + 1 >= G) begin m_st[i] <= 1'b0; m_cnt[i] <= 0; end
                else m_cnt[i] <= m_cnt[i] + 1;
            end
        end
    end

    function automatic logic exp_pg(logic e, logic p, logic [N-1:0] s);
        return e && p && (&s);
    endfunction

    task automatic chk(input string tag, input logic [N:0] act, input logic [N:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    bit model_on = 1'b0;
    always @(negedge clk) begin
        if (model_on)
            chk("R1 R3 R5 model", {pgood, status}, {exp_pg(en, pw, m_st), m_st});
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    bit done = 1'b0;
    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        for (int i = 0; i < N; i++) m_cnt[i] = 0;
        cyc(3);
        chk("R9 reset", {pgood, status}, '0);
        rst = 1'b0; en = 1'b1; pw = 1'b1;
        model_on = 1'b1;
        above = 4'b1111;
        cyc(Q - 1);
        chk("R1 before window", {pgood, status}, 5'b0_0000);
        cyc(1);
        chk("R1 R10 qualified", {pgood, status}, 5'b1_1111);
        // R3 fall after G low samples, R5 neighbours unaffected
        above[0] = 1'b0;
        cyc(G - 1);
        chk("R3 still high", {pgood, status}, 5'b1_1111);
        cyc(1);
        chk("R3 R5 fallen", {pgood, status}, 5'b0_1110);
        // R2 interruption restarts qualification
        above[0] = 1'b1;
        cyc(Q / 2);
        above[0] = 1'b0;
        cyc(1);
        above[0] = 1'b1;
        cyc(Q - 1);
        chk("R2 restart pending", {pgood, status}, 5'b0_1110);
        cyc(1);
        chk("R2 requalified", {pgood, status}, 5'b1_1111);
        // R4 short dip ignored
        above[1] = 1'b0;
        cyc(G - 1);
        above[1] = 1'b1;
        cyc(1);
        above[1] = 1'b0;
        cyc(G - 1);
        above[1] = 1'b1;
        cyc(2);
        chk("R4 dip ignored", {pgood, status}, 5'b1_1111);
        // R6 enable drop
        en = 1'b0;
        #1;
        chk("R6 pgood immediate", {pgood, status}, 5'b0_1111);
        cyc(1);
        chk("R6 status low", {pgood, status}, 5'b0_0000);
        cyc(3);
        en = 1'b1;
        cyc(Q - 1);
        chk("R7 not yet", {pgood, status}, 5'b0_0000);
        cyc(1);
        chk("R7 requalified", {pgood, status}, 5'b1_1111);
        // R8 lockout
        pw = 1'b0;
        cyc(1);
        chk("R8 lockout low", {pgood, status}, 5'b0_0000);
        cyc(2 * Q);
        chk("R8 held low", {pgood, status}, 5'b0_0000);
        pw = 1'b1;
        cyc(Q);
        chk("R8 restart", {pgood, status}, 5'b1_1111);
        // Random phase: channel 3 tied high (R10)
        for (int k = 0; k < 6000; k++) begin
            for (int i = 0; i < N - 1; i++) begin
                if (above[i]) begin
                    if ($urandom_range(0, 29) == 0) above[i] = 1'b0;
                end else if ($urandom_range(0, 2) == 0 || $urandom_range(0, 9) == 0) begin
                    above[i] = 1'b1;
                end
            end
            if ($urandom_range(0, 399) == 0) en = ~en;
            if (!en && $urandom_range(0, 19) == 0) en = 1'b1;
            if ($urandom_range(0, 599) == 0) pw = 1'b0;
            else if (!pw && $urandom_range(0, 14) == 0) pw = 1'b1;
            cyc(1);
        end
        // Final: tied channel must be good after full window (R10)
        en = 1'b1; pw = 1'b1;
        cyc(Q + 1);
        chk("R10 tied channel good", {1'b0, status[3]}, 2'b01);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule